// File: doc/BRIEF.md
# Dual-rail delay-insensitive pipeline stage

This block is a clock-emulated model of a single stage in a delay-insensitive pipeline. Each bit is carried on a pair of rails: a false rail and a true rail. Every rail of the holding register is a state-holding threshold gate with hysteresis. All state lives in flip-flops on a free-running clock, so the model can be synthesized. Wavefronts move under a four-phase handshake, not under a clock edge. The stage accepts a DATA wavefront only while the downstream stage requests DATA. It accepts a NULL wavefront only while the downstream stage requests NULL. A completion detector sees when the held word is entirely DATA or entirely NULL, and then flips the acknowledge that goes back upstream.

The completion detector has two levels. The first level ORs the two rails of each output bit. Groups of these ORs then feed all-of-n hysteretic gates, which act as C-elements. At the root, a two-state phase machine joins the group results. In state `PH_RFD` the stage requests DATA and `ack_o` is 1. Transition `T_ARM` moves it to `PH_RFN` once every group reports DATA. In `PH_RFN` the stage requests NULL and `ack_o` is 0. Transition `T_DRAIN` returns it to `PH_RFD` once every group reports NULL. An error flag shows, one cycle late, any input bit that carries the illegal code.

Top module: `dr_pipe_stage`

## Requirements
- R1: Bit i uses the pair (`d_f[i]`, `d_t[i]`). The code (1,0) is DATA0, (0,1) is DATA1, (0,0) is NULL and (1,1) is illegal. The output pair (`q_f[i]`, `q_t[i]`) uses the same code.
- R2: Each threshold gate with threshold m over n inputs behaves as follows. Its registered output rises once at least m inputs are 1. It falls only once all n inputs are 0. Otherwise it keeps its value.
- R3: While `rst_n` is low and after it is released, all output rails are 0, `ack_o` is 1 and `err_o` is 0.
- R4: While `req_i` is 0, an output rail that is 0 stays 0, whatever arrives on the data rails.
- R5: While `req_i` is 1, an output rail that is 1 stays 1, whatever arrives on the data rails.
- R6: `ack_o` falls to 0 only after every output bit holds DATA. With inputs applied before clock edge k and `req_i` at 1, `ack_o` is still 1 after edge k+1 and is 0 after edge k+2.
- R7: `ack_o` rises to 1 only after every output bit holds NULL. It has the same two-edge lag behind the output rails as in R6.
- R8: A word that is only partly DATA, or partly NULL, leaves `ack_o` at its previous value for as long as the word stays incomplete.
- R9: `err_o` is 1 in the cycle after an edge at which any input bit carried (1,1). It is 0 in the cycle after an edge at which no input bit did.
- R10: When `req_i` permits it, each output rail copies its input rail at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulation clock |
| rst_n | input | 1 | Active-low synchronous reset |
| d_f | input | N_BITS | False rails of the incoming word |
| d_t | input | N_BITS | True rails of the incoming word |
| req_i | input | 1 | Request from the next stage: 1 = DATA wanted, 0 = NULL wanted |
| q_f | output | N_BITS | False rails of the held word |
| q_t | output | N_BITS | True rails of the held word |
| ack_o | output | 1 | Acknowledge to the previous stage: 1 = DATA wanted, 0 = NULL wanted |
| err_o | output | 1 | An illegal (1,1) code was seen on an input bit |

## Verification
The hardest situation to reach is an incomplete wavefront held for a long time. In that case the hysteresis of the group gates, and of the phase machine, must keep `ack_o` still even though most rails have already moved. The stimulus builds this on purpose. It drives DATA on all bits but the top one, waits, and only then completes the word. For the return it lowers every bit to NULL except bit 0. A request held in the wrong phase while new wavefronts arrive shows that the register rails are gated. Random DATA words, with both DATA codes mixed across the bits, test the rail copy and the exact cycle in which `ack_o` changes.

// File: rtl/dr_pkg.sv
package dr_pkg;

    // Phase of the stage as seen from upstream
    typedef enum logic {
        PH_RFD = 1'b0,   // requesting DATA, ack high
        PH_RFN = 1'b1    // requesting NULL, ack low
    } phase_e;

    // Rail pair encoding for one bit (false rail, true rail)
    localparam logic [1:0] CODE_NULL  = 2'b00;
    localparam logic [1:0] CODE_DATA1 = 2'b01;
    localparam logic [1:0] CODE_DATA0 = 2'b10;
    localparam logic [1:0] CODE_BAD   = 2'b11;

endpackage

// File: rtl/thresh_gate.sv
module thresh_gate #(
    parameter int N_IN = 2,
    parameter int M_TH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] a,
    output logic            y
);
    int   cnt;
    logic y_nxt;

    always_comb begin
        cnt = $countones(a);
        if (cnt >= M_TH)
            y_nxt = 1'b1;
        else if (cnt == 0)
            y_nxt = 1'b0;
        else
            y_nxt = y;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            y <= 1'b0;
        else
            y <= y_nxt;
    end

    // R2: rises only after reaching the threshold
    p_rise_threshold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(y) |-> ($past(cnt) >= M_TH));
    // R2: falls only after every input has dropped
    p_fall_all_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(y) |-> ($past(cnt) == 0));
endmodule

// File: rtl/dr_reg_bank.sv
module dr_reg_bank #(
    parameter int N_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_BITS-1:0] d_f,
    input  logic [N_BITS-1:0] d_t,
    input  logic              req_i,
    output logic [N_BITS-1:0] q_f,
    output logic [N_BITS-1:0] q_t
);
    for (genvar b = 0; b < N_BITS; b++) begin : g_bit
        // each rail is an all-of-two gate joining the data rail and the request
        thresh_gate #(.N_IN(2), .M_TH(2)) u_rail_f (
            .clk(clk), .rst_n(rst_n), .a({d_f[b], req_i}), .y(q_f[b]));
        thresh_gate #(.N_IN(2), .M_TH(2)) u_rail_t (
            .clk(clk), .rst_n(rst_n), .a({d_t[b], req_i}), .y(q_t[b]));

        // R4: a rail takes on DATA only under a DATA request
        p_set_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(q_f[b]) || $rose(q_t[b])) |-> $past(req_i));
        // R5: a rail releases only under a NULL request
        p_clr_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(q_f[b]) || $fell(q_t[b])) |-> !$past(req_i));
    end
endmodule

// File: rtl/dr_completion.sv
module dr_completion #(
    parameter int N_BITS = 8,
    parameter int GRP_W  = 4,
    localparam int NUM_GRP = (N_BITS + GRP_W - 1) / GRP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_BITS-1:0]  q_f,
    input  logic [N_BITS-1:0]  q_t,
    output logic [NUM_GRP-1:0] grp_done
);
    logic [N_BITS-1:0] bit_valid;

    // a bit counts as present when either rail is set
    always_comb bit_valid = q_f | q_t;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int LO = g * GRP_W;
        localparam int GW = (LO + GRP_W > N_BITS) ? (N_BITS - LO) : GRP_W;
        thresh_gate #(.N_IN(GW), .M_TH(GW)) u_celem (
            .clk(clk), .rst_n(rst_n), .a(bit_valid[LO +: GW]), .y(grp_done[g]));
    end
endmodule

// File: rtl/dr_pipe_stage.sv
module dr_pipe_stage #(
    parameter int N_BITS = 8,
    parameter int GRP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_BITS-1:0] d_f,
    input  logic [N_BITS-1:0] d_t,
    input  logic              req_i,
    output logic [N_BITS-1:0] q_f,
    output logic [N_BITS-1:0] q_t,
    output logic              ack_o,
    output logic              err_o
);
    import dr_pkg::*;

    localparam int NUM_GRP = (N_BITS + GRP_W - 1) / GRP_W;

    logic [NUM_GRP-1:0] grp_done;
    logic               all_hi;
    logic               all_lo;
    phase_e             ph_q;
    phase_e             ph_d;

    dr_reg_bank #(.N_BITS(N_BITS)) u_bank (
        .clk(clk), .rst_n(rst_n), .d_f(d_f), .d_t(d_t), .req_i(req_i),
        .q_f(q_f), .q_t(q_t));

    dr_completion #(.N_BITS(N_BITS), .GRP_W(GRP_W)) u_cd (
        .clk(clk), .rst_n(rst_n), .q_f(q_f), .q_t(q_t), .grp_done(grp_done));

    always_comb begin
        all_hi = &grp_done;
        all_lo = ~|grp_done;
    end

    // next phase: the root C-element of the completion tree
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_RFD: if (all_hi) ph_d = PH_RFN;  // T_ARM
            PH_RFN: if (all_lo) ph_d = PH_RFD;  // T_DRAIN
            default: ph_d = PH_RFD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ph_q <= PH_RFD;
        else
            ph_q <= ph_d;
    end

    always_comb ack_o = (ph_q == PH_RFD);

    always_ff @(posedge clk) begin
        if (!rst_n)
            err_o <= 1'b0;
        else
            err_o <= |(d_f & d_t);
    end

    // R6: acknowledge drops only after every group saw DATA
    p_ack_fall_complete_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_o) |-> $past(all_hi));
    // R7: acknowledge rises only after every group saw NULL
    p_ack_rise_complete_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(all_lo));
    // R8: with a mixed set of groups the phase holds
    p_ack_hold_partial_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_hi && !all_lo) |=> $stable(ack_o));
    // R9: the flag follows the illegal code by one cycle
    p_err_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(|(d_f & d_t)));
endmodule

// File: tb/test_dr_pipe_stage.sv
module test_dr_pipe_stage;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] d_f = '0;
    logic [N-1:0] d_t = '0;
    logic         req_i = 1'b1;
    logic [N-1:0] q_f;
    logic [N-1:0] q_t;
    logic         ack_o;
    logic         err_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dr_pipe_stage #(.N_BITS(N), .GRP_W(4)) i_dr_pipe_stage (
        .clk(clk), .rst_n(rst_n), .d_f(d_f), .d_t(d_t), .req_i(req_i),
        .q_f(q_f), .q_t(q_t), .ack_o(ack_o), .err_o(err_o));

    // Expected rails of a DATA word (R1): true rail carries the value, false its inverse
    function automatic logic [N-1:0] rail_t(input logic [N-1:0] v);
        return v;
    endfunction
    function automatic logic [N-1:0] rail_f(input logic [N-1:0] v);
        return ~v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put_data(input logic [N-1:0] v);
        d_t = rail_t(v);
        d_f = rail_f(v);
    endtask

    task automatic put_null();
        d_t = '0;
        d_f = '0;
    endtask

    // full DATA then NULL cycle with the exact acknowledge timing
    task automatic wave(input logic [N-1:0] v);
        req_i = 1'b1;
        put_data(v);
        step(1);
        chk("R10 q_t", 32'(q_t), 32'(rail_t(v)));
        chk("R1 q_f", 32'(q_f), 32'(rail_f(v)));
        step(1);
        chk("R6 ack not early", 32'(ack_o), 32'd1);
        step(1);
        chk("R6 ack low", 32'(ack_o), 32'd0);
        req_i = 1'b0;
        put_null();
        step(1);
        chk("R10 null rails", 32'({q_t, q_f}), 32'd0);
        step(1);
        chk("R7 ack not early", 32'(ack_o), 32'd0);
        step(1);
        chk("R7 ack high", 32'(ack_o), 32'd1);
    endtask

    initial begin
        logic [N-1:0] w;
        void'($urandom(32'h5EED_0042));
        step(2);
        chk("R3 reset rails", 32'({q_t, q_f}), 32'd0);
        chk("R3 reset ack", 32'(ack_o), 32'd1);
        chk("R3 reset err", 32'(err_o), 32'd0);
        rst_n = 1'b1;
        step(1);
        chk("R3 after release", 32'({ack_o, q_t, q_f}), 32'h10000);

        // directed corner words
        wave('0);
        wave('1);
        wave(8'hA5);

        // R4: a DATA word under a NULL request is not taken
        req_i = 1'b0;
        w = 8'h3C;
        put_data(w);
        step(3);
        chk("R4 blocked rails", 32'({q_t, q_f}), 32'd0);
        chk("R4 ack held", 32'(ack_o), 32'd1);
        req_i = 1'b1;
        step(1);
        chk("R4 taken on request", 32'(q_t), 32'(rail_t(w)));
        step(2);
        chk("R6 ack after late request", 32'(ack_o), 32'd0);

        // R5: NULL under a DATA request does not release
        put_null();
        step(3);
        chk("R5 rails held", 32'(q_t), 32'(rail_t(w)));
        chk("R5 ack held", 32'(ack_o), 32'd0);
        req_i = 1'b0;
        step(3);
        chk("R5 released", 32'({q_t, q_f}), 32'd0);
        chk("R7 ack back", 32'(ack_o), 32'd1);

        // R8 and R2: partial DATA word, top bit still NULL
        req_i = 1'b1;
        w = 8'h5A;
        put_data(w);
        d_t[N-1] = 1'b0;
        d_f[N-1] = 1'b0;
        step(4);
        chk("R8 partial data ack", 32'(ack_o), 32'd1);
        d_t[N-1] = w[N-1];
        d_f[N-1] = ~w[N-1];
        step(3);
        chk("R8 completed data ack", 32'(ack_o), 32'd0);
        // R8 and R2: partial NULL, bit 0 still DATA
        req_i = 1'b0;
        put_null();
        d_t[0] = w[0];
        d_f[0] = ~w[0];
        step(4);
        chk("R8 partial null ack", 32'(ack_o), 32'd0);
        chk("R8 bit0 kept", 32'({q_t[0], q_f[0]}), 32'({w[0], ~w[0]}));
        d_t[0] = 1'b0;
        d_f[0] = 1'b0;
        step(3);
        chk("R8 completed null ack", 32'(ack_o), 32'd1);

        // R9: illegal code on bit 2
        d_t[2] = 1'b1;
        d_f[2] = 1'b1;
        step(1);
        chk("R9 err raised", 32'(err_o), 32'd1);
        put_null();
        step(1);
        chk("R9 err cleared", 32'(err_o), 32'd0);

        // random DATA words
        for (int i = 0; i < 24; i++) begin
            wave(N'($urandom()));
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule